// File: doc/BRIEF.md
# Clock-Slaved Synchronous Serial Transceiver

This block is a serial port that never generates its own shift clock. An external master drives the clock pin, and one data line carries traffic in either direction, one direction at a time. The block splits that line into an input, an output and an output enable. On the transmit side, words written over a small register interface land in a holding register. From there they pass into a shift register and leave least significant bit first. On the receive side, a shift register gathers bits and hands each finished word to a receive buffer, which software then reads.

The external clock is resynchronised into the system clock domain, and its edges are detected there. Outgoing data changes after a falling edge and incoming data is sampled on a rising edge. Words are 8 or 9 bits long; the length is chosen separately for each direction. Two flags show whether the transmit holding register is free and whether a received word is waiting. Each flag can raise an interrupt output when its enable is set. If software clears an enable, the matching path stops and its logic returns to idle.

Top module: `sync_slave_port`

## Requirements
- R1: The port is active only while `cfg_port_en`=1, `cfg_sync_mode`=1 and `cfg_clk_int`=0. While inactive, nothing is shifted out, `sd_oe` stays 0 and no received word is loaded.
- R2: A word in the shift register drives its bit 0 on `sd_out` with `sd_oe`=1. Each falling clock-pin edge moves to the next bit. After the falling edge that ends the last bit, `sd_oe` returns to 0 unless another word follows.
- R3: The holding register and the shift register form a two-deep queue. A write clears `st_tx_empty`. `st_tx_empty` sets again only when the held word moves into the shift register, so a word written during shifting keeps the flag clear until the current word ends. After reset `st_tx_empty` is 1.
- R4: With receive enabled, `sd_in` is sampled on each rising clock-pin edge, least significant bit first. After the last bit the word moves to the buffer (`rd_data`, `rd_bit9`) and `st_rx_full` sets. A one-cycle `rd_strobe` clears `st_rx_full`.
- R5: With `cfg_tx_nine`=1, a 9-bit word is sent whose bit 8 is the `wr_bit9` value written with it. With `cfg_rx_nine`=1, 9 bits are received and bit 8 appears on `rd_bit9`. In 8-bit mode `rd_bit9` is 0.
- R6: If a word completes while `st_rx_full`=1, `st_rx_ovr` sets and the buffer keeps its old word. Further words are not loaded while `st_rx_ovr`=1. Clearing `cfg_rx_en` or `cfg_port_en` clears `st_rx_ovr` and discards any partial word.
- R7: Clearing `cfg_tx_en` or `cfg_port_en` drops `sd_oe` and empties the shift register. When transmit is enabled again, no partially sent word resumes.
- R8: `irq_tx` equals `st_tx_empty` AND `cfg_tx_ie`; `irq_rx` equals `st_rx_full` AND `cfg_rx_ie`.
- R9: A word written while transmit is disabled stays held. When transmit is enabled, it moves to the shift register and bit 0 appears on `sd_out`, before any clock-pin edge.
- R10: After a word is loaded into the shift register, a falling clock-pin edge that has no rising edge before it does not advance the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_port_en | input | 1 | Serial port enable |
| cfg_sync_mode | input | 1 | Synchronous mode select |
| cfg_clk_int | input | 1 | Internal clock source select (must be 0 for this port) |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Continuous receive enable |
| cfg_tx_nine | input | 1 | 9-bit transmit words |
| cfg_rx_nine | input | 1 | 9-bit receive words |
| cfg_tx_ie | input | 1 | Transmit-empty interrupt enable |
| cfg_rx_ie | input | 1 | Receive-full interrupt enable |
| wr_valid | input | 1 | One-cycle write of the transmit holding register |
| wr_data | input | 8 | Transmit data bits 7..0 |
| wr_bit9 | input | 1 | Transmit bit 8, captured with the write |
| rd_strobe | input | 1 | One-cycle read of the receive buffer |
| rd_data | output | 8 | Receive buffer bits 7..0 |
| rd_bit9 | output | 1 | Receive buffer bit 8 |
| st_tx_empty | output | 1 | Holding register handed off, free for a new word |
| st_rx_full | output | 1 | Receive buffer holds an unread word |
| st_rx_ovr | output | 1 | Receive overrun latched |
| irq_tx | output | 1 | Gated transmit interrupt |
| irq_rx | output | 1 | Gated receive interrupt |
| sck_in | input | 1 | External shift clock pin |
| sd_in | input | 1 | Data line, input side |
| sd_out | output | 1 | Data line, output side |
| sd_oe | output | 1 | Data line output enable |

## Verification
The bench writes a second word while the first is still shifting. A design that raised the empty flag on the write, or let the new word overwrite the shifter, would show the flag early or send corrupted bits. A falling clock edge is given just after a word is loaded, with no rising edge before it; a design that counted it would skip bit 0. For receive, a word is completed with the buffer still unread and then again after a read. A design that overwrote the buffer or cleared the overrun on the read would change `rd_data`. Mid-word aborts on both paths catch designs that resume a stale bit count.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Word length in bits for a given base width and ninth-bit mode.
  function automatic int unsigned ssp_word_len(input logic nine, input int unsigned base_w);
    return nine ? base_w + 1 : base_w;
  endfunction

  // The port only runs from the external clock in synchronous mode.
  function automatic logic ssp_port_active(input logic port_en, input logic sync_mode,
                                           input logic clk_int);
    return port_en & sync_mode & ~clk_int;
  endfunction

endpackage

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_rise,
  output logic pin_fall
);
  localparam int unsigned SR_W = STAGES + 1;

  logic [SR_W-1:0] sr_q;
  logic            synced;
  logic            prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[SR_W-2:0], pin_in};
  end

  assign synced   = sr_q[STAGES-1];
  assign prev     = sr_q[STAGES];
  assign pin_rise = synced & ~prev;
  assign pin_fall = ~synced & prev;

endmodule

// File: rtl/ssp_tx_path.sv
module ssp_tx_path
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_run,
  input  logic              nine,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              sck_rise,
  input  logic              sck_fall,
  output logic              sd_out,
  output logic              sd_oe,
  output logic              tx_empty
);
  localparam int unsigned WORD_W = DATA_W + 1;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  logic              hold_vld;
  logic [WORD_W-1:0] hold_word;
  logic              sh_busy;
  logic [WORD_W-1:0] sh_word;
  logic [CNT_W-1:0]  sh_idx;
  logic [CNT_W-1:0]  sh_last;
  logic              seen_rise;
  logic              empty_q;

  // Named internal events
  logic handoff;
  logic bit_adv;
  logic word_end;

  always_comb begin
    handoff  = hold_vld & ~sh_busy & tx_run;
    bit_adv  = sh_busy & tx_run & sck_fall & seen_rise;
    word_end = bit_adv & (sh_idx == sh_last);
  end

  // Holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_word <= '0;
    end else if (wr_valid) begin
      hold_vld  <= 1'b1;
      hold_word <= {wr_bit9, wr_data};
    end else if (handoff) begin
      hold_vld  <= 1'b0;
    end
  end

  // Empty flag: a write clears it, a handoff sets it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        empty_q <= 1'b1;
    else if (wr_valid) empty_q <= 1'b0;
    else if (handoff)  empty_q <= 1'b1;
  end

  // Shift register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_busy   <= 1'b0;
      sh_word   <= '0;
      sh_idx    <= '0;
      sh_last   <= '0;
      seen_rise <= 1'b0;
    end else if (!tx_run) begin
      sh_busy   <= 1'b0;
      sh_idx    <= '0;
      seen_rise <= 1'b0;
    end else if (handoff) begin
      sh_busy   <= 1'b1;
      sh_word   <= hold_word;
      sh_idx    <= '0;
      sh_last   <= CNT_W'(ssp_word_len(nine, DATA_W) - 1);
      seen_rise <= 1'b0;
    end else if (sh_busy) begin
      if (bit_adv) begin
        seen_rise <= 1'b0;
        if (word_end) begin
          sh_busy <= 1'b0;
        end else begin
          sh_idx  <= sh_idx + 1'b1;
          sh_word <= {1'b0, sh_word[WORD_W-1:1]};
        end
      end else if (sck_rise) begin
        seen_rise <= 1'b1;
      end
    end
  end

  assign sd_out   = sh_word[0];
  assign sd_oe    = sh_busy & tx_run;
  assign tx_empty = empty_q;

  assert_empty_rise_on_handoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty_q) |-> $past(handoff));

  assert_idx_in_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> (sh_idx <= sh_last));

  assert_abort_empties_shifter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_run |=> !sh_busy);

  assert_fall_needs_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_busy && sck_fall && !seen_rise) |=> $stable(sh_word));

endmodule

// File: rtl/ssp_rx_path.sv
module ssp_rx_path
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_run,
  input  logic              nine,
  input  logic              sd_in,
  input  logic              sck_rise,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              rx_full,
  output logic              rx_ovr
);
  localparam int unsigned WORD_W = DATA_W + 1;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] rsr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] buf_q;
  logic              full_q;
  logic              ovr_q;

  // Named internal events
  logic              take_bit;
  logic              word_done;
  logic              buf_load;
  logic [WORD_W-1:0] rsr_next;
  logic [CNT_W-1:0]  last_idx;

  // Right-justify a word gathered from the top of the shift register.
  function automatic logic [WORD_W-1:0] rx_align(input logic [WORD_W-1:0] r, input logic n);
    return n ? r : {1'b0, r[WORD_W-1:1]};
  endfunction

  always_comb begin
    last_idx  = CNT_W'(ssp_word_len(nine, DATA_W) - 1);
    take_bit  = rx_run & sck_rise;
    word_done = take_bit & (cnt_q == last_idx);
    buf_load  = word_done & ~ovr_q & ~full_q;
    rsr_next  = {sd_in, rsr_q[WORD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsr_q <= '0;
      cnt_q <= '0;
    end else if (!rx_run) begin
      rsr_q <= '0;
      cnt_q <= '0;
    end else if (take_bit) begin
      rsr_q <= word_done ? '0 : rsr_next;
      cnt_q <= word_done ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        buf_q <= '0;
    else if (buf_load) buf_q <= rx_align(rsr_next, nine);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         full_q <= 1'b0;
    else if (buf_load)  full_q <= 1'b1;
    else if (rd_strobe) full_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ovr_q <= 1'b0;
    else if (!rx_run)              ovr_q <= 1'b0;
    else if (word_done && full_q)  ovr_q <= 1'b1;
  end

  assign rd_data = buf_q[DATA_W-1:0];
  assign rd_bit9 = buf_q[DATA_W];
  assign rx_full = full_q;
  assign rx_ovr  = ovr_q;

  assert_ovr_keeps_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> $stable(buf_q));

  assert_completion_on_full_overruns_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && full_q) |=> ovr_q);

  assert_read_clears_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !buf_load) |=> !full_q);

endmodule

// File: rtl/sync_slave_port.sv
module sync_slave_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_port_en,
  input  logic              cfg_sync_mode,
  input  logic              cfg_clk_int,
  input  logic              cfg_tx_en,
  input  logic              cfg_rx_en,
  input  logic              cfg_tx_nine,
  input  logic              cfg_rx_nine,
  input  logic              cfg_tx_ie,
  input  logic              cfg_rx_ie,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              st_tx_empty,
  output logic              st_rx_full,
  output logic              st_rx_ovr,
  output logic              irq_tx,
  output logic              irq_rx,
  input  logic              sck_in,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              sd_oe
);
  logic port_active;
  logic tx_run;
  logic rx_run;
  logic sck_rise;
  logic sck_fall;

  assign port_active = ssp_port_active(cfg_port_en, cfg_sync_mode, cfg_clk_int);
  assign tx_run      = port_active & cfg_tx_en;
  assign rx_run      = port_active & cfg_rx_en;

  ssp_edge_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (sck_in),
    .pin_rise (sck_rise),
    .pin_fall (sck_fall)
  );

  ssp_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_run   (tx_run),
    .nine     (cfg_tx_nine),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .wr_bit9  (wr_bit9),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .sd_out   (sd_out),
    .sd_oe    (sd_oe),
    .tx_empty (st_tx_empty)
  );

  ssp_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_run    (rx_run),
    .nine      (cfg_rx_nine),
    .sd_in     (sd_in),
    .sck_rise  (sck_rise),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .rd_bit9   (rd_bit9),
    .rx_full   (st_rx_full),
    .rx_ovr    (st_rx_ovr)
  );

  assign irq_tx = st_tx_empty & cfg_tx_ie;
  assign irq_rx = st_rx_full & cfg_rx_ie;

  assert_inactive_no_rx_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !port_active |=> !$rose(st_rx_full));

  assert_inactive_line_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !port_active |-> !sd_oe);

endmodule

// File: tb/sync_slave_port_bench.sv
`timescale 1ns/1ps
module sync_slave_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_port_en = 0, cfg_sync_mode = 0, cfg_clk_int = 0, cfg_tx_en = 0, cfg_rx_en = 0;
  logic cfg_tx_nine = 0, cfg_rx_nine = 0, cfg_tx_ie = 0, cfg_rx_ie = 0;
  logic wr_valid = 0, wr_bit9 = 0, rd_strobe = 0, sck_in = 0, sd_in = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rd_bit9, st_tx_empty, st_rx_full, st_rx_ovr, irq_tx, irq_rx, sd_out, sd_oe;

  always #4 clk = ~clk;

  sync_slave_port u_sync_slave_port (
    .clk(clk), .rst_n(rst_n), .cfg_port_en(cfg_port_en), .cfg_sync_mode(cfg_sync_mode),
    .cfg_clk_int(cfg_clk_int), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
    .cfg_tx_nine(cfg_tx_nine), .cfg_rx_nine(cfg_rx_nine), .cfg_tx_ie(cfg_tx_ie),
    .cfg_rx_ie(cfg_rx_ie), .wr_valid(wr_valid), .wr_data(wr_data), .wr_bit9(wr_bit9),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_bit9(rd_bit9), .st_tx_empty(st_tx_empty),
    .st_rx_full(st_rx_full), .st_rx_ovr(st_rx_ovr), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .sck_in(sck_in), .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe));

  int checks = 0, fails = 0, settle = 0, cyc = 0;
  bit cmp_on = 0, finished = 0;

  // Behavioural reference state
  int m_hold = 0, m_word = 0, m_nbits = 8, m_idx = 0, m_buf = 0;
  int m_rx_sh = 0, m_rx_cnt = 0;
  bit m_hold_v = 0, m_busy = 0, m_seen = 0, m_empty = 1, m_full = 0, m_ovr = 0;

  function automatic bit active_m();
    return cfg_port_en && cfg_sync_mode && !cfg_clk_int;
  endfunction
  function automatic bit tx_run_m();
    return active_m() && cfg_tx_en;
  endfunction
  function automatic bit rx_run_m();
    return active_m() && cfg_rx_en;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_handoff();
    if (m_hold_v && !m_busy && tx_run_m()) begin
      m_busy = 1; m_word = m_hold; m_nbits = cfg_tx_nine ? 9 : 8;
      m_idx = 0; m_seen = 0; m_hold_v = 0; m_empty = 1;
    end
  endtask

  task automatic cfg_done();
    if (!tx_run_m()) begin m_busy = 0; m_seen = 0; end
    if (!rx_run_m()) begin m_rx_cnt = 0; m_rx_sh = 0; m_ovr = 0; end
    model_handoff();
    settle = 6;
    repeat (8) @(posedge clk);
  endtask

  task automatic sck_edge(bit v);
    @(posedge clk); #1;
    sck_in = v;
    if (v) begin
      if (m_busy) m_seen = 1;
      if (rx_run_m()) begin
        m_rx_sh = m_rx_sh | (int'(sd_in) << m_rx_cnt);
        m_rx_cnt++;
        if (m_rx_cnt == (cfg_rx_nine ? 9 : 8)) begin
          if (!m_ovr) begin
            if (m_full) m_ovr = 1;
            else begin m_buf = m_rx_sh; m_full = 1; end
          end
          m_rx_sh = 0; m_rx_cnt = 0;
        end
      end
    end else if (m_busy && m_seen) begin
      m_seen = 0;
      if (m_idx == m_nbits - 1) begin m_busy = 0; model_handoff(); end
      else m_idx++;
    end
    settle = 6;
    repeat (10) @(posedge clk);
  endtask

  task automatic write_word(int w);
    @(posedge clk); #1;
    wr_valid = 1; wr_data = w[7:0]; wr_bit9 = w[8];
    @(posedge clk); #1;
    wr_valid = 0;
    m_hold_v = 1; m_hold = w; m_empty = 0;
    model_handoff();
    settle = 6;
    repeat (8) @(posedge clk);
  endtask

  task automatic read_buf();
    @(posedge clk); #1;
    rd_strobe = 1;
    @(posedge clk); #1;
    rd_strobe = 0;
    m_full = 0;
    settle = 6;
    repeat (8) @(posedge clk);
  endtask

  // Shift a word out, checking each bit while the clock pin is high.
  task automatic shift_out(int n, int w, string req);
    for (int i = 0; i < n; i++) begin
      sck_edge(1);
      @(negedge clk);
      chk(req, $sformatf("sd_out bit%0d", i), int'(sd_out), (w >> i) & 1);
      sck_edge(0);
    end
  endtask

  task automatic recv(int n, int w);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      sd_in = w[i];
      sck_edge(1);
      sck_edge(0);
    end
  endtask

  // Per-clock comparison against the reference once outputs have settled
  always @(negedge clk) begin
    if (cmp_on) begin
      if (settle > 0) settle--;
      else begin
        chk("R3", "tx_empty", int'(st_tx_empty), int'(m_empty));
        chk("R4", "rx_full", int'(st_rx_full), int'(m_full));
        chk("R6", "rx_ovr", int'(st_rx_ovr), int'(m_ovr));
        chk("R2", "sd_oe", int'(sd_oe), int'(m_busy));
        if (m_busy) chk("R2", "sd_out", int'(sd_out), (m_word >> m_idx) & 1);
        chk("R4", "rd_data", int'(rd_data), m_buf & 8'hFF);
        chk("R5", "rd_bit9", int'(rd_bit9), (m_buf >> 8) & 1);
        chk("R8", "irq_tx", int'(irq_tx), int'(m_empty && cfg_tx_ie));
        chk("R8", "irq_rx", int'(irq_rx), int'(m_full && cfg_rx_ie));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R3", "reset tx_empty", int'(st_tx_empty), 1);
    chk("R4", "reset rx_full", int'(st_rx_full), 0);
    chk("R2", "reset sd_oe", int'(sd_oe), 0);
    chk("R8", "reset irq", int'(irq_tx | irq_rx), 0);
    cmp_on = 1;

    // R1: internal clock source selected, port must stay idle
    @(posedge clk); #1;
    cfg_port_en = 1; cfg_sync_mode = 1; cfg_clk_int = 1; cfg_tx_en = 1; cfg_rx_en = 1;
    cfg_done();
    write_word(9'h099);
    @(negedge clk) chk("R1", "inactive sd_oe", int'(sd_oe), 0);
    recv(8, 8'hFF);
    @(negedge clk) chk("R1", "inactive rx_full", int'(st_rx_full), 0);

    // R9: held word launches when transmit is enabled
    @(posedge clk); #1;
    cfg_tx_en = 0; cfg_rx_en = 0; cfg_clk_int = 0;
    cfg_done();
    @(negedge clk) chk("R9", "disabled oe", int'(sd_oe), 0);
    @(posedge clk); #1;
    cfg_tx_en = 1;
    cfg_done();
    @(negedge clk);
    chk("R9", "enable oe", int'(sd_oe), 1);
    chk("R9", "enable bit0", int'(sd_out), 1);
    chk("R3", "empty after handoff", int'(st_tx_empty), 1);

    // R3: second word waits in the holding register
    write_word(9'h03C);
    @(negedge clk);
    chk("R3", "empty held clear", int'(st_tx_empty), 0);
    shift_out(8, 9'h099, "R2");
    @(negedge clk);
    chk("R3", "empty at second handoff", int'(st_tx_empty), 1);
    chk("R3", "second word bit0", int'(sd_out), 0);
    chk("R3", "second word oe", int'(sd_oe), 1);
    shift_out(8, 9'h03C, "R2");
    @(negedge clk) chk("R2", "oe after word", int'(sd_oe), 0);

    // R8: transmit interrupt gating
    @(posedge clk); #1;
    cfg_tx_ie = 1;
    cfg_done();
    @(negedge clk) chk("R8", "irq_tx", int'(irq_tx), 1);

    // R5: 9-bit transmit
    @(posedge clk); #1;
    cfg_tx_nine = 1;
    cfg_done();
    write_word(9'h155);
    shift_out(9, 9'h155, "R5");
    @(posedge clk); #1;
    cfg_tx_nine = 0; cfg_tx_ie = 0;
    cfg_done();

    // R10: falling edge with no prior rising edge after load
    sck_edge(1);
    write_word(9'h00E);
    sck_edge(0);
    @(negedge clk) chk("R10", "bit0 kept", int'(sd_out), 0);
    shift_out(3, 9'h00E, "R10");

    // R7: abort mid-word
    @(posedge clk); #1;
    cfg_tx_en = 0;
    cfg_done();
    @(negedge clk) chk("R7", "abort oe", int'(sd_oe), 0);
    @(posedge clk); #1;
    cfg_tx_en = 1;
    cfg_done();
    @(negedge clk) chk("R7", "no resume", int'(sd_oe), 0);
    write_word(9'h0C3);
    shift_out(8, 9'h0C3, "R7");

    // R4: 8-bit receive
    @(posedge clk); #1;
    cfg_tx_en = 0; cfg_rx_en = 1; cfg_rx_ie = 1;
    cfg_done();
    recv(8, 9'h05A);
    @(negedge clk);
    chk("R4", "rx_full", int'(st_rx_full), 1);
    chk("R4", "rd_data", int'(rd_data), 8'h5A);
    chk("R8", "irq_rx", int'(irq_rx), 1);
    read_buf();
    @(negedge clk) chk("R4", "read clears", int'(st_rx_full), 0);

    // R5: 9-bit receive
    @(posedge clk); #1;
    cfg_rx_nine = 1;
    cfg_done();
    recv(9, 9'h1C3);
    @(negedge clk);
    chk("R5", "rd_data", int'(rd_data), 8'hC3);
    chk("R5", "rd_bit9", int'(rd_bit9), 1);

    // R6: overrun keeps buffer and blocks loads
    recv(9, 9'h011);
    @(negedge clk);
    chk("R6", "ovr set", int'(st_rx_ovr), 1);
    chk("R6", "buf kept", int'(rd_data), 8'hC3);
    read_buf();
    recv(9, 9'h022);
    @(negedge clk);
    chk("R6", "blocked full", int'(st_rx_full), 0);
    chk("R6", "blocked data", int'(rd_data), 8'hC3);
    @(posedge clk); #1;
    cfg_rx_en = 0;
    cfg_done();
    @(negedge clk) chk("R6", "ovr cleared", int'(st_rx_ovr), 0);
    @(posedge clk); #1;
    cfg_rx_en = 1; cfg_rx_nine = 0;
    cfg_done();
    recv(3, 9'h007);
    @(posedge clk); #1;
    cfg_port_en = 0;
    cfg_done();
    @(posedge clk); #1;
    cfg_port_en = 1;
    cfg_done();
    recv(8, 9'h081);
    @(negedge clk);
    chk("R6", "partial discarded", int'(rd_data), 8'h81);
    chk("R5", "bit9 in 8-bit mode", int'(rd_bit9), 0);

    repeat (20) @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule